// File: doc/BRIEF.md
# Multi-Mode Host Bus Receiver

This block is the host-facing front end of a display controller. A single set of host pins can carry bytes in one of four ways: an 8-bit parallel bus with separate active-low read and write strobes (8080 style), an 8-bit parallel bus with a read/write select and an active-high enable (6800 style), a 4-wire SPI with a separate data/command pin, or a 3-wire SPI whose 9-bit frames carry the data/command flag as their first bit. A 3-bit strap code chooses the bus. The I2C code is recognised but parked: nothing is accepted and the pins are never driven.

Every accepted byte leaves the block on one internal stream as a single-cycle strobe. The byte comes with a flag that tells display data from a command byte. On a parallel read, the block drives the byte presented on an internal readback port and raises the output enable for the data pins. All host pins pass through two-flop synchronisers into the core clock, and strobe and serial-clock edges are found there. Each strobe or serial-clock phase must therefore last at least three core clocks.

Top module: `hostbus_rx`

## Requirements
- R1: Mode code bus_mode selects the bus: 3'b110 is the 8080-style bus, 3'b100 the 6800-style bus, 3'b000 4-wire SPI and 3'b001 3-wire SPI. 3'b010 (I2C) and every other code accept no byte and never raise host_d_oe.
- R2: While host_cs_n is high, host_d_oe is low and no byte is accepted on any bus.
- R3: In 8080 mode a byte is captured from host_d_i when host_wr_rw rises. rx_is_data equals host_dc (1 = display data, 0 = command).
- R4: In 8080 mode host_d_oe is high exactly while host_cs_n and host_rd_en are both low, and host_d_o equals rb_byte.
- R5: In 6800 mode a byte is captured when host_rd_en (enable) falls while host_wr_rw (read/write) is low. A falling enable with read/write high produces no byte.
- R6: In 6800 mode host_d_oe is high exactly while host_cs_n is low and host_wr_rw and host_rd_en are both high.
- R7: In 4-wire SPI, host_d_i[0] is the serial clock and host_d_i[1] is the serial data. Bits are taken MSB first on rising serial-clock edges. host_dc is sampled together with the eighth bit and gives rx_is_data.
- R8: In 3-wire SPI, each frame has 9 bits. The first bit is rx_is_data and the next eight bits are the byte, MSB first.
- R9: A high level on host_cs_n clears the serial bit count, so a partial frame is dropped and the next frame starts cleanly.
- R10: rx_valid is high for one core clock per accepted byte, and only if chip select was low at the pins three clocks earlier.
- R11: In the serial modes host_d_oe stays low, so host_d_i[7:2] are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 3 | Static bus-select strap code |
| host_cs_n | input | 1 | Chip select, active low |
| host_dc | input | 1 | Data (1) / command (0) select |
| host_wr_rw | input | 1 | 8080 write strobe (active low) or 6800 read/write (1 = read) |
| host_rd_en | input | 1 | 8080 read strobe (active low) or 6800 enable (active high) |
| host_d_i | input | 8 | Data pins as seen at the input buffers |
| host_d_o | output | 8 | Byte driven onto the data pins during a read |
| host_d_oe | output | 1 | Output enable for the data pins |
| rb_byte | input | 8 | Internal readback byte for host reads |
| rx_valid | output | 1 | One-cycle strobe for an accepted byte |
| rx_byte | output | 8 | Accepted byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
The assertions check four things on every cycle:
- the pin enable never rises in a serial or parked mode, or with chip select high;
- no byte appears in the parked or undefined modes;
- each accepted byte is a one-cycle pulse;
- chip select was low at the pins three clocks before that pulse.

The byte values, the bit ordering and the data/command flag can only be shown by the bench's scenarios. The bench sweeps all 256 byte values through every accepting mode and compares each result against arithmetic expectations. The same applies to the strobe polarity, the rejection of 6800 reads as writes, and the dropping of a partial serial frame.

// File: rtl/hostbus_rx.sv
module hostbus_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_mode,
  input  logic          host_cs_n,
  input  logic          host_dc,
  input  logic          host_wr_rw,
  input  logic          host_rd_en,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe,
  input  logic [DW-1:0] rb_byte,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          rx_is_data
);
  localparam int PW = DW + 4;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST4 = CW'(DW - 1);
  localparam logic [CW-1:0] LAST3 = CW'(DW);
  localparam logic [PW-1:0] IDLE  = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic m8080, m6800, mspi4, mspi3;
  assign m8080 = bus_mode == 3'b110;
  assign m6800 = bus_mode == 3'b100;
  assign mspi4 = bus_mode == 3'b000;
  assign mspi3 = bus_mode == 3'b001;

  logic [PW-1:0] meta, sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= IDLE;
      sync <= IDLE;
    end else begin
      meta <= {host_cs_n, host_dc, host_wr_rw, host_rd_en, host_d_i};
      sync <= meta;
    end

  logic s_cs_n, s_dc, s_wr, s_rd;
  logic [DW-1:0] s_d;
  assign {s_cs_n, s_dc, s_wr, s_rd, s_d} = sync;

  logic p_wr, p_rd, p_sck;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_wr  <= 1'b1;
      p_rd  <= 1'b1;
      p_sck <= 1'b0;
    end else begin
      p_wr  <= s_wr;
      p_rd  <= s_rd;
      p_sck <= s_d[0];
    end

  logic wr_rise, en_fall, sck_rise;
  assign wr_rise  = m8080 & ~p_wr & s_wr;
  assign en_fall  = m6800 & p_rd & ~s_rd & ~s_wr;
  assign sck_rise = (mspi4 | mspi3) & ~p_sck & s_d[0];

  logic [DW-2:0] shreg;
  logic [CW-1:0] bitcnt;
  logic          flag3;
  logic [DW-1:0] shifted;
  assign shifted = {shreg, s_d[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      rx_is_data <= 1'b0;
      shreg      <= '0;
      bitcnt     <= '0;
      flag3      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (s_cs_n) begin
        bitcnt <= '0;
      end else if (wr_rise | en_fall) begin
        rx_valid   <= 1'b1;
        rx_byte    <= s_d;
        rx_is_data <= s_dc;
      end else if (sck_rise) begin
        if (mspi3 && bitcnt == '0) begin
          flag3  <= s_d[1];
          bitcnt <= bitcnt + 1'b1;
        end else begin
          shreg <= shifted[DW-2:0];
          if ((mspi4 && bitcnt == LAST4) || (mspi3 && bitcnt == LAST3)) begin
            rx_valid   <= 1'b1;
            rx_byte    <= shifted;
            rx_is_data <= mspi4 ? s_dc : flag3;
            bitcnt     <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end

  assign host_d_oe = ~host_cs_n & ((m8080 & ~host_rd_en) | (m6800 & host_wr_rw & host_rd_en));
  assign host_d_o  = rb_byte;
endmodule

module hostbus_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_mode,
  input logic       host_cs_n,
  input logic       host_d_oe,
  input logic       rx_valid
);
  // R11
  serial_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_d_oe |-> (bus_mode == 3'b110 || bus_mode == 3'b100));
  // R2
  cs_gates_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_d_oe |-> !host_cs_n);
  // R1
  parked_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bus_mode == 3'b110 || bus_mode == 3'b100 ||
                  bus_mode == 3'b000 || bus_mode == 3'b001));
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  cs_before_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(host_cs_n, 3));
endmodule

bind hostbus_rx hostbus_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .host_cs_n(host_cs_n),
  .host_d_oe(host_d_oe), .rx_valid(rx_valid)
);

// File: tb/hostbus_rx_tb.sv
`timescale 1ns/1ps
module hostbus_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_mode = 3'b110;
  logic cs_n = 1'b1, dc = 1'b0, wr_rw = 1'b1, rd_en = 1'b1;
  logic [7:0] d_i = '0, rb = '0;
  logic [7:0] d_o, rx_byte;
  logic d_oe, rx_valid, rx_is_data;
  int errors = 0, checks = 0;
  logic [8:0] q[$];

  always #4 clk = ~clk;

  hostbus_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .host_cs_n(cs_n),
    .host_dc(dc), .host_wr_rw(wr_rw), .host_rd_en(rd_en), .host_d_i(d_i),
    .host_d_o(d_o), .host_d_oe(d_oe), .rb_byte(rb), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_is_data(rx_is_data)
  );

  always @(negedge clk) if (rx_valid) q.push_back({rx_is_data, rx_byte});

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic expect_one(string tag, logic dcx, logic [7:0] b);
    chk({tag, " count"}, 9'(q.size()), 9'd1);
    if (q.size() > 0) chk(tag, q[0], {dcx, b});
    q.delete();
  endtask

  task automatic expect_none(string tag);
    chk(tag, 9'(q.size()), 9'd0);
    q.delete();
  endtask

  task automatic wr8080(logic dcx, logic [7:0] b);
    dc = dcx; d_i = b; cs_n = 0; idle(2);
    wr_rw = 0; idle(4); wr_rw = 1; idle(4); cs_n = 1; idle(3);
  endtask

  task automatic wr6800(logic rw, logic dcx, logic [7:0] b);
    dc = dcx; d_i = b; wr_rw = rw; cs_n = 0; idle(2);
    rd_en = 1; idle(4); rd_en = 0; idle(4); cs_n = 1; idle(3);
  endtask

  task automatic sbit(logic v);
    d_i[0] = 0; d_i[1] = v; idle(3); d_i[0] = 1; idle(3);
  endtask

  task automatic spi4(logic dcx, logic [7:0] b, int nbits);
    dc = dcx; d_i = '0; cs_n = 0; idle(2);
    for (int i = 7; i > 7 - nbits; i--) sbit(b[i]);
    d_i[0] = 0; idle(4); cs_n = 1; idle(3);
  endtask

  task automatic spi3(logic dcx, logic [7:0] b);
    dc = 0; d_i = '0; cs_n = 0; idle(2);
    sbit(dcx);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    d_i[0] = 0; idle(4); cs_n = 1; idle(3);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(3);
    chk("R10 reset rx_valid", {8'd0, rx_valid}, 9'd0);
    chk("R2 reset oe", {8'd0, d_oe}, 9'd0);

    // R3 8080 write sweep
    bus_mode = 3'b110; idle(3);
    for (int v = 0; v < 256; v++) begin
      wr8080(v[0] ^ v[5], 8'(v));
      expect_one("R3 8080 write", v[0] ^ v[5], 8'(v));
    end
    // R4 8080 read
    rb = 8'h3C; cs_n = 0; rd_en = 0; #1;
    chk("R4 8080 oe", {8'd0, d_oe}, 9'd1);
    chk("R4 8080 byte", {1'b0, d_o}, {1'b0, 8'h3C});
    rd_en = 1; #1;
    chk("R4 8080 oe off", {8'd0, d_oe}, 9'd0);
    cs_n = 1; rd_en = 0; #1;
    chk("R2 cs high no drive", {8'd0, d_oe}, 9'd0);
    rd_en = 1; idle(4);
    // R2 strobe with cs high
    d_i = 8'h77; wr_rw = 0; idle(4); wr_rw = 1; idle(5);
    expect_none("R2 cs high no byte");

    // R5 6800 writes
    rd_en = 0; bus_mode = 3'b100; idle(4);
    for (int v = 0; v < 256; v++) begin
      wr6800(1'b0, v[2], 8'(255 - v));
      expect_one("R5 6800 write", v[2], 8'(255 - v));
    end
    wr6800(1'b1, 1'b1, 8'h5A);
    expect_none("R5 6800 read not a write");
    // R6 6800 read
    rb = 8'hC3; wr_rw = 1; cs_n = 0; rd_en = 1; #1;
    chk("R6 6800 oe", {8'd0, d_oe}, 9'd1);
    chk("R6 6800 byte", {1'b0, d_o}, {1'b0, 8'hC3});
    wr_rw = 0; #1;
    chk("R6 6800 oe off on write", {8'd0, d_oe}, 9'd0);
    rd_en = 0; cs_n = 1; idle(4); q.delete();

    // R7 4-wire SPI
    wr_rw = 1; rd_en = 1; bus_mode = 3'b000; idle(4);
    for (int v = 0; v < 256; v++) begin
      spi4(v[1], 8'(v * 37 + 11), 8);
      expect_one("R7 spi4 byte", v[1], 8'(v * 37 + 11));
    end
    cs_n = 0; rd_en = 0; #1;
    chk("R11 spi4 no drive", {8'd0, d_oe}, 9'd0);
    cs_n = 1; rd_en = 1; idle(3);
    // R9 partial frame dropped
    spi4(1'b0, 8'hFF, 5);
    expect_none("R9 partial frame");
    spi4(1'b1, 8'hA5, 8);
    expect_one("R9 after partial", 1'b1, 8'hA5);

    // R8 3-wire SPI
    bus_mode = 3'b001; idle(4);
    for (int v = 0; v < 256; v++) begin
      spi3(v[3] ^ v[0], 8'(v ^ 8'h96));
      expect_one("R8 spi3 byte", v[3] ^ v[0], 8'(v ^ 8'h96));
    end
    spi4(1'b0, 8'hFF, 4);
    expect_none("R9 spi3 partial");
    spi3(1'b0, 8'h81);
    expect_one("R9 spi3 after partial", 1'b0, 8'h81);
    cs_n = 0; wr_rw = 1; rd_en = 1; #1;
    chk("R11 spi3 no drive", {8'd0, d_oe}, 9'd0);
    cs_n = 1; idle(3);

    // R1 parked I2C and undefined code
    bus_mode = 3'b010; idle(4);
    wr8080(1'b1, 8'h42); spi4(1'b1, 8'h42, 8); wr6800(1'b0, 1'b1, 8'h42);
    expect_none("R1 i2c parked");
    cs_n = 0; rd_en = 0; #1;
    chk("R1 i2c no drive", {8'd0, d_oe}, 9'd0);
    cs_n = 1; rd_en = 1;
    bus_mode = 3'b111; idle(4);
    wr8080(1'b0, 8'h24); spi4(1'b0, 8'h24, 8);
    expect_none("R1 undefined code");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule